// File: doc/BRIEF.md
# Lockable Pin Configuration Register Bank

This block holds the electrical and function-select configuration for a set of 32 pads. Each pad has one word-wide register on a simple memory-mapped bus. The register carries six one-bit electrical controls, a three-bit function selector and a lock bit. Every field is driven straight out to per-pin output ports, so the pad ring and the function multiplexers see each change in the cycle after the bus write.

Two write-only broadcast registers let firmware set up many pads with one full-word write. Each one covers half of the pads. The upper half of the written word picks which pads are updated, and the lower half is the new low configuration half for each of them. The lock bit freezes a pad's configuration against direct writes and broadcast writes alike. Only a reset releases it.

The bus accepts one request per cycle. The bank answers every request exactly one cycle later, with read data for reads and zero for writes.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: After reset, every pin register reads 0x00000742. That value means pull enable set (bit 1), drive strength set (bit 6), function select 7 (bits 10:8), and lock clear (bit 15).
- R2: A write to pin register n (byte offset 4n) updates bits 7:0 when byte enable 0 is set and bits 15:8 when byte enable 1 is set. Only bits 0,1,2,4,5,6, 10:8 and 15 are stored. All other bits, including 31:16, read as zero.
- R3: While a register's lock bit (bit 15) is 1, direct writes leave its bits 15:0 unchanged, and so do broadcast writes.
- R4: The lock bit can only be set by a write. Writing 0 to it does not clear it. Reset returns it to 0, after which the register accepts writes again.
- R5: A full-word write to offset 0x80 copies bits 15:0 of the data into every pin register k (0 to 15) whose enable bit 16+k is set. Pins whose enable bit is clear are left alone.
- R6: A full-word write to offset 0x84 does the same for pins 16 to 31, with data bit 16+k selecting pin 16+k.
- R7: In a broadcast write, locked pins are skipped while the enabled unlocked pins in the same write are updated.
- R8: A broadcast write with byte enables other than 4'hF changes nothing. Reads of 0x80 and 0x84 return zero.
- R9: Reads of offsets from 0x88 upward return zero, and writes to them change no register.
- R10: Every request gets resp_valid exactly one cycle after it is presented. For a read, resp_rdata carries the data in that cycle.
- R11: The per-pin output ports always equal the corresponding stored fields of each pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | 32 | Read data, zero for writes |
| pull_up | output | 32 | Pull direction per pin, 1 = up |
| pull_en | output | 32 | Pull resistor enable per pin |
| slew_slow | output | 32 | Slow slew per pin |
| pfilt_en | output | 32 | Passive input filter enable per pin |
| odrain_en | output | 32 | Open-drain enable per pin |
| drive_hi | output | 32 | High drive strength per pin |
| func_sel | output | 96 | Function select, 3 bits per pin, pin n at [3n+2:3n] |
| cfg_locked | output | 32 | Lock state per pin |

## Verification
A wrong stored field shows on the per-pin ports in the cycle after the bad write. It also shows in the read-back one cycle after a read request, so a full read sweep of all pins after each stimulus phase catches it at once. A lost or leaking lock only shows when a later write is made to that pin. For that reason the lock phases follow each lock with direct and broadcast writes that aim at locked and unlocked pins together. A misrouted broadcast enable shows as a wrong pin changing in the neighbouring half, so broadcasts use asymmetric enable masks in both halves.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int GROUP_PINS = 16;

    // stored bits of the low configuration half
    localparam logic [HALF_W-1:0] CFG_KEEP_MASK = 16'h8777;
    localparam logic [HALF_W-1:0] CFG_RST_HALF  = 16'h0742;

    typedef struct packed {
        logic       lock;
        logic [2:0] func;
        logic       drive_hi;
        logic       odrain;
        logic       pfilt;
        logic       slew_slow;
        logic       pull_en;
        logic       pull_up;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_PIN,
        ACC_BCAST,
        ACC_VOID
    } acc_kind_e;

    function automatic pin_cfg_t cfg_from_half(logic [HALF_W-1:0] h);
        pin_cfg_t c;
        c.pull_up   = h[0];
        c.pull_en   = h[1];
        c.slew_slow = h[2];
        c.pfilt     = h[4];
        c.odrain    = h[5];
        c.drive_hi  = h[6];
        c.func      = h[10:8];
        c.lock      = h[15];
        return c;
    endfunction

    function automatic logic [HALF_W-1:0] cfg_to_half(pin_cfg_t c);
        logic [HALF_W-1:0] h;
        h        = '0;
        h[0]     = c.pull_up;
        h[1]     = c.pull_en;
        h[2]     = c.slew_slow;
        h[4]     = c.pfilt;
        h[5]     = c.odrain;
        h[6]     = c.drive_hi;
        h[10:8]  = c.func;
        h[15]    = c.lock;
        return h;
    endfunction

    function automatic logic [HALF_W-1:0] lane_mask(logic [1:0] be_lo);
        return {{8{be_lo[1]}}, {8{be_lo[0]}}};
    endfunction

endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
    import pcfg_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_be,
    input  logic [HALF_W-1:0]    bc_enables,
    output logic [NPINS-1:0]     pin_dir_we,
    output logic [NPINS-1:0]     pin_bc_we,
    output logic [HALF_W-1:0]    dir_mask,
    output acc_kind_e            rd_kind,
    output logic [$clog2(NPINS)-1:0] rd_idx
);
    localparam int NGROUPS = NPINS / GROUP_PINS;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int PIDX_W  = $clog2(NPINS);

    logic [WIDX_W-1:0]  word_idx;
    logic               is_pin;
    logic [NGROUPS-1:0] grp_hit;
    logic               wr_go;

    assign word_idx = req_addr[ADDR_W-1:2];
    assign is_pin   = int'(word_idx) < NPINS;
    assign wr_go    = req_valid && req_write;
    assign dir_mask = lane_mask(req_be[1:0]);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign grp_hit[g] = wr_go && (req_be == 4'hF) &&
                            (int'(word_idx) == NPINS + g);
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pin_dir_we[p] = wr_go && (int'(word_idx) == p);
        assign pin_bc_we[p]  = grp_hit[p / GROUP_PINS] && bc_enables[p % GROUP_PINS];
    end

    always_comb begin
        rd_kind = ACC_IDLE;
        if (req_valid && !req_write) begin
            if (is_pin)                                  rd_kind = ACC_PIN;
            else if (int'(word_idx) < NPINS + NGROUPS)   rd_kind = ACC_BCAST;
            else                                         rd_kind = ACC_VOID;
        end
    end

    assign rd_idx = word_idx[PIDX_W-1:0];

    // R2: a direct write reaches at most one register
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pin_dir_we));

    // R9: no register is written by an access outside the pin range
    a_r9_void_no_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_pin) |-> (pin_dir_we == '0));

endmodule

// File: rtl/pcfg_pin_reg.sv
module pcfg_pin_reg
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_we,
    input  logic [HALF_W-1:0] dir_mask,
    input  logic [HALF_W-1:0] dir_data,
    input  logic              bc_we,
    input  logic [HALF_W-1:0] bc_data,
    output pin_cfg_t          cfg
);
    pin_cfg_t          cfg_q;
    pin_cfg_t          cfg_d;
    logic [HALF_W-1:0] cur_half;
    logic [HALF_W-1:0] merged;

    assign cur_half = cfg_to_half(cfg_q);
    assign merged   = (cur_half & ~dir_mask) | (dir_data & dir_mask);

    always_comb begin
        cfg_d = cfg_q;
        if (!cfg_q.lock) begin
            if (dir_we)     cfg_d = cfg_from_half(merged);
            else if (bc_we) cfg_d = cfg_from_half(bc_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_from_half(CFG_RST_HALF);
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R3: a locked register holds its value against any write
    a_r3_locked_frozen: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lock |=> $stable(cfg_q));

    // R4: the lock never falls while out of reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lock |=> cfg_q.lock);

endmodule

// File: rtl/pcfg_read_port.sv
module pcfg_read_port
    import pcfg_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  acc_kind_e                rd_kind,
    input  logic [$clog2(NPINS)-1:0] rd_idx,
    input  pin_cfg_t [NPINS-1:0]     cfg_vec,
    output logic                     resp_valid,
    output logic [WORD_W-1:0]        resp_rdata
);
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (rd_kind == ACC_PIN)
            rd_word[HALF_W-1:0] = cfg_to_half(cfg_vec[rd_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank
    import pcfg_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [3:0]           req_be,
    output logic                 resp_valid,
    output logic [31:0]          resp_rdata,
    output logic [NPINS-1:0]     pull_up,
    output logic [NPINS-1:0]     pull_en,
    output logic [NPINS-1:0]     slew_slow,
    output logic [NPINS-1:0]     pfilt_en,
    output logic [NPINS-1:0]     odrain_en,
    output logic [NPINS-1:0]     drive_hi,
    output logic [3*NPINS-1:0]   func_sel,
    output logic [NPINS-1:0]     cfg_locked
);
    localparam int PIDX_W = $clog2(NPINS);

    logic [NPINS-1:0]    pin_dir_we;
    logic [NPINS-1:0]    pin_bc_we;
    logic [HALF_W-1:0]   dir_mask;
    acc_kind_e           rd_kind;
    logic [PIDX_W-1:0]   rd_idx;
    pin_cfg_t [NPINS-1:0] cfg_vec;

    pcfg_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .bc_enables (req_wdata[31:16]),
        .pin_dir_we (pin_dir_we),
        .pin_bc_we  (pin_bc_we),
        .dir_mask   (dir_mask),
        .rd_kind    (rd_kind),
        .rd_idx     (rd_idx)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pcfg_pin_reg u_reg (
            .clk      (clk),
            .rst      (rst),
            .dir_we   (pin_dir_we[p]),
            .dir_mask (dir_mask),
            .dir_data (req_wdata[HALF_W-1:0]),
            .bc_we    (pin_bc_we[p]),
            .bc_data  (req_wdata[HALF_W-1:0]),
            .cfg      (cfg_vec[p])
        );

        assign pull_up[p]         = cfg_vec[p].pull_up;
        assign pull_en[p]         = cfg_vec[p].pull_en;
        assign slew_slow[p]       = cfg_vec[p].slew_slow;
        assign pfilt_en[p]        = cfg_vec[p].pfilt;
        assign odrain_en[p]       = cfg_vec[p].odrain;
        assign drive_hi[p]        = cfg_vec[p].drive_hi;
        assign func_sel[3*p +: 3] = cfg_vec[p].func;
        assign cfg_locked[p]      = cfg_vec[p].lock;
    end

    pcfg_read_port #(.NPINS(NPINS)) u_read (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .rd_kind    (rd_kind),
        .rd_idx     (rd_idx),
        .cfg_vec    (cfg_vec),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata)
    );

    // R10: one response per request, one cycle later
    a_r10_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R2: unstored bits never appear in read data
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((resp_rdata & ~{16'h0, CFG_KEEP_MASK}) == 32'h0));

    // R9: reads beyond the pin registers return zero
    a_r9_high_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (int'(req_addr[ADDR_W-1:2]) >= NPINS))
        |=> (resp_rdata == 32'h0));

endmodule

// File: tb/pinmux_cfg_bank_tb.sv
module pinmux_cfg_bank_tb;
    localparam int NP = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic [NP-1:0] pull_up, pull_en, slew_slow, pfilt_en, odrain_en, drive_hi, cfg_locked;
    logic [3*NP-1:0] func_sel;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [NP];

    always #5 clk = ~clk;

    pinmux_cfg_bank u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .pull_up(pull_up), .pull_en(pull_en), .slew_slow(slew_slow),
        .pfilt_en(pfilt_en), .odrain_en(odrain_en), .drive_hi(drive_hi),
        .func_sel(func_sel), .cfg_locked(cfg_locked)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) mdl[i] = 32'h0000_0742;
    endtask

    function automatic logic [31:0] after_direct(logic [31:0] old, logic [31:0] d, logic [3:0] be);
        logic [31:0] bm;
        if (old[15]) return old;
        bm = {16'h0, {8{be[1]}}, {8{be[0]}}};
        return ((old & ~bm) | (d & bm)) & 32'h0000_8777;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        int idx;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check32("R10", "write resp_valid", {31'h0, resp_valid}, 32'h1);
        idx = int'(a) / 4;
        if (idx < NP) mdl[idx] = after_direct(mdl[idx], d, be);
        else if ((idx == NP || idx == NP + 1) && be == 4'hF) begin
            for (int k = 0; k < 16; k++) begin
                int p;
                p = (idx - NP) * 16 + k;
                if (d[16+k] && !mdl[p][15]) mdl[p] = {16'h0, d[15:0]} & 32'h0000_8777;
            end
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check32("R10", "read resp_valid", {31'h0, resp_valid}, 32'h1);
        d = resp_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int i = 0; i < NP; i++) begin
            bus_read(8'(4 * i), d);
            check32(req, $sformatf("pin %0d readback", i), d, mdl[i]);
        end
        for (int i = 0; i < NP; i++) begin
            logic [31:0] pv;
            pv = {16'h0, cfg_locked[i], 4'h0, func_sel[3*i +: 3], 1'b0,
                  drive_hi[i], odrain_en[i], pfilt_en[i], 1'b0,
                  slew_slow[i], pull_en[i], pull_up[i]};
            check32("R11", $sformatf("pin %0d ports", i), pv, mdl[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        check32("R10", "idle resp_valid", {31'h0, resp_valid}, 32'h0);
        check_all("R1");

        // R2: direct writes over all pins, all lane combinations, lock bit kept clear
        for (int i = 0; i < NP; i++) begin
            logic [31:0] pat;
            pat = (32'hFFFF_0000 | (32'(i) * 32'h0000_1357)) & ~32'h0000_8000;
            bus_write(8'(4 * i), pat, 4'(i % 4) | 4'hC);
        end
        check_all("R2");
        for (int i = 0; i < NP; i++) bus_write(8'(4 * i), 32'hFFFF_7FFF, 4'hF);
        check_all("R2");

        // R5 and R6: broadcast halves with asymmetric enables
        bus_write(8'h80, 32'hA5A5_0215, 4'hF);
        check_all("R5");
        bus_write(8'h84, 32'h0F0F_0533, 4'hF);
        check_all("R6");

        // R8: partial-width broadcast dropped, broadcast regs read zero
        bus_write(8'h80, 32'hFFFF_0000, 4'h7);
        bus_write(8'h84, 32'hFFFF_0000, 4'hE);
        check_all("R8");
        bus_read(8'h80, d); check32("R8", "bcast lo read", d, 32'h0);
        bus_read(8'h84, d); check32("R8", "bcast hi read", d, 32'h0);

        // R9: unmapped accesses
        bus_write(8'h88, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'hFC, 32'h0000_0000, 4'hF);
        bus_read(8'h88, d); check32("R9", "read 0x88", d, 32'h0);
        bus_read(8'hC0, d); check32("R9", "read 0xC0", d, 32'h0);
        check_all("R9");

        // R4: lock every third pin using only lane 1
        for (int i = 0; i < NP; i += 3) bus_write(8'(4 * i), 32'h0000_8300, 4'h2);
        check_all("R4");
        bus_write(8'h00, 32'h0000_0000, 4'hF);
        check_all("R4");

        // R3: direct writes to every pin, locked ones must hold
        for (int i = 0; i < NP; i++) bus_write(8'(4 * i), 32'h0000_0577, 4'hF);
        check_all("R3");

        // R7: full broadcast across both halves with locked pins mixed in
        bus_write(8'h80, 32'hFFFF_0001, 4'hF);
        bus_write(8'h84, 32'hFFFF_0660, 4'hF);
        check_all("R7");

        // R4: reset releases the lock
        do_reset();
        check_all("R4");
        bus_write(8'h00, 32'h0000_0011, 4'hF);
        check_all("R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule